// File: doc/BRIEF.md
# HDB3/AMI Line Encoder

This block turns a serial NRZ bit stream into the two unipolar rails of a bipolar line code. One rail carries positive marks and the other carries negative marks. Outside the block the two rails are summed into a three-level line signal. A mode pin chooses between two codes. With the pin high, the block runs full HDB3, which replaces every run of four zeros with a substitution pattern that holds a code violation. With the pin low, it runs plain alternate mark inversion, with no substitution.

The block takes one bit on every rising edge of the transmit clock. A four-entry look-ahead shift register lets it rewrite the first zero of a run once the fourth zero arrives. Because of this register, every bit appears on the rails exactly four clock periods after it is presented. Rail pulses are return-to-zero: they are high only during the high half of the clock period. An OR of both rails is also brought out, so that a loopback path can use it as a clock-bearing signal.

A line coder cannot stall the line, so there is no valid/ready handshake at either edge. The source must present a new bit before every rising edge, and the rails never apply back-pressure. The mode pin is a plain control input that is sampled together with each bit.

Top module: `hdb3_line_encoder`

## Requirements
- R1: While `rst_n` is low, all three outputs are low. After reset, the remembered last pulse polarity is negative, so the first pulse produced is positive, and the mark parity is even.
- R2: A bit that is set up before rising edge n appears on the rails during the clock period that follows rising edge n+3, which is four periods after it was presented.
- R3: Each input 1 produces one pulse, and its polarity is opposite to the previous pulse. A positive pulse is `rail_p` high and a negative pulse is `rail_n` high.
- R4: In HDB3 mode, if an odd number of pulses has been sent since the last violation, a run of four zeros is sent as 0,0,0,V. V has the same polarity as the pulse before it.
- R5: In HDB3 mode, if an even number of pulses has been sent since the last violation, a run of four zeros is sent as B,0,0,V. B is opposite in polarity to the pulse before it, and V has the same polarity as B.
- R6: The parity counts every mark and every B since the last V, and it returns to even at each substitution. A long zero run is therefore coded in independent groups of four, for example eight zeros give two substitutions.
- R7: In AMI mode, zeros never produce a pulse, however long the run is.
- R8: `rail_p` and `rail_n` are never high together, and `rail_any` equals their OR.
- R9: During the low half of the clock period all three outputs are low.
- R10: The mode pin is sampled with each bit. The mode value sampled with the fourth zero of a run decides whether that run is substituted, even when the earlier zeros of the run were sampled in the other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; bits are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_en | input | 1 | 1 selects HDB3 with zero substitution, 0 selects plain AMI |
| nrz_in | input | 1 | Serial NRZ data bit |
| rail_p | output | 1 | Positive-mark rail, return-to-zero |
| rail_n | output | 1 | Negative-mark rail, return-to-zero |
| rail_any | output | 1 | OR of both rails, for loopback clock recovery |

## Verification
The risky cycle is the one in which the fourth zero of a run enters the look-ahead. On that edge the input stage writes V into the first stage and B into the last stage. At the same edge the output stage has just resolved the polarity of the pulse ahead of the run, and B must follow that pulse. Patterns that place a mark immediately before a zero run, back-to-back runs of eight or more zeros, and mode changes in the middle of a run all provoke this coincidence. Every rail sample in the high phase is then compared with an expected sequence derived independently from the substitution and alternation rules, and short sequences are also compared with hand-written expectations.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // Zero-run length replaced by a substitution pattern; fixed by the code.
  localparam int RUN_LEN = 4;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_BAL  = 2'd3
  } sym_t;
endpackage

// File: rtl/hdb3_lookahead.sv
module hdb3_lookahead
  import hdb3_pkg::*;
#(
  parameter int DEPTH = RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_en,
  input  logic nrz_in,
  output sym_t sym_out
);
  localparam int ZW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [ZW-1:0] ZLAST = ZW'(DEPTH - 1);

  sym_t            stage [DEPTH];
  logic [ZW-1:0]   zrun;        // consecutive zeros entered, saturating
  logic            odd_marks;   // pulses since last violation is odd
  logic            subst;
  logic            need_bal;

  assign subst    = hdb3_en && !nrz_in && (zrun == ZLAST);
  assign need_bal = subst && !odd_marks;
  assign sym_out  = stage[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= SYM_ZERO;
      zrun      <= '0;
      odd_marks <= 1'b0;
    end else begin
      stage[0] <= subst ? SYM_VIOL : (nrz_in ? SYM_MARK : SYM_ZERO);
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      // first zero of the run is moving into the last stage right now
      if (need_bal) stage[DEPTH-1] <= SYM_BAL;

      if (nrz_in || subst)   zrun <= '0;
      else if (zrun != ZLAST) zrun <= zrun + 1'b1;

      if (subst)       odd_marks <= 1'b0;
      else if (nrz_in) odd_marks <= ~odd_marks;
    end
  end

  // R5: a balancing pulse only exists together with its violation
  a_r5_bal_with_viol: assert property (@(posedge clk) disable iff (!rst_n)
    (stage[DEPTH-1] == SYM_BAL) |-> (stage[0] == SYM_VIOL));

  // R6: parity restarts even whenever a violation is issued
  a_r6_viol_clears_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (stage[0] == SYM_VIOL) |-> !odd_marks);

  // R7: plain AMI never creates a violation
  a_r7_ami_no_subst: assert property (@(posedge clk) disable iff (!rst_n)
    !hdb3_en |=> (stage[0] != SYM_VIOL));
endmodule

// File: rtl/hdb3_polarity.sv
module hdb3_polarity
  import hdb3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym,
  output logic lvl_p,
  output logic lvl_n
);
  logic last_pos;   // polarity of the most recent pulse, 1 = positive
  logic pulse;
  logic flip;
  logic pos;

  always_comb begin
    pulse = (sym != SYM_ZERO);
    flip  = (sym == SYM_MARK) || (sym == SYM_BAL);
    pos   = flip ? ~last_pos : last_pos;
    lvl_p = pulse && pos;
    lvl_n = pulse && !pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_pos <= 1'b0;
    else if (flip) last_pos <= ~last_pos;
  end

  // R3: every ordinary mark toggles the remembered polarity
  a_r3_mark_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (sym == SYM_MARK) |=> (last_pos != $past(last_pos)));

  // R4: a violation leaves the remembered polarity untouched
  a_r4_viol_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (sym == SYM_VIOL) |=> $stable(last_pos));
endmodule

// File: rtl/hdb3_rz_gate.sv
module hdb3_rz_gate #(
  parameter int RAILS = 2
) (
  input  logic             clk,
  input  logic [RAILS-1:0] lvl,
  output logic [RAILS-1:0] rz,
  output logic             any
);
  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    assign rz[g] = lvl[g] & clk;   // high only in the high half-period
  end
  assign any = |rz;
endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
  import hdb3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_en,
  input  logic nrz_in,
  output logic rail_p,
  output logic rail_n,
  output logic rail_any
);
  sym_t       sym;
  logic [1:0] lvl;
  logic [1:0] rz;

  hdb3_lookahead #(.DEPTH(RUN_LEN)) u_look (
    .clk     (clk),
    .rst_n   (rst_n),
    .hdb3_en (hdb3_en),
    .nrz_in  (nrz_in),
    .sym_out (sym)
  );

  hdb3_polarity u_pol (
    .clk   (clk),
    .rst_n (rst_n),
    .sym   (sym),
    .lvl_p (lvl[1]),
    .lvl_n (lvl[0])
  );

  hdb3_rz_gate #(.RAILS(2)) u_rz (
    .clk (clk),
    .lvl (lvl),
    .rz  (rz),
    .any (rail_any)
  );

  assign rail_p = rz[1];
  assign rail_n = rz[0];

  // R8: the two rail levels are mutually exclusive
  a_r8_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lvl[1] && lvl[0]));
endmodule

// File: tb/tb_hdb3_line_encoder.sv
`timescale 1ns/1ps
module tb_hdb3_line_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdb3_en = 1'b1;
  logic nrz_in = 1'b0;
  logic rail_p, rail_n, rail_any;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  hdb3_line_encoder dut (
    .clk(clk), .rst_n(rst_n), .hdb3_en(hdb3_en), .nrz_in(nrz_in),
    .rail_p(rail_p), .rail_n(rail_n), .rail_any(rail_any)
  );

  // stimulus table: 16 bits sent MSB first, with the mode for the row
  localparam int ROWS = 6;
  localparam logic [15:0] PAT_BITS [ROWS] = '{
    16'b1011_0000_1000_0110,
    16'b0000_0000_0000_0000,
    16'b1000_0100_0011_0000,
    16'b0000_0000_0000_0000,
    16'b1100_1010_0011_0000,
    16'b0111_0000_0000_1000
  };
  localparam logic PAT_MODE [ROWS] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic       d_bit  [112];
  logic       d_mode [112];
  logic [1:0] d_exp  [112];   // {positive, negative}
  string      d_tag  [112];
  logic [1:0] h_exp  [16];

  task automatic check(input bit ok, input string tag,
                       input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    nrz_in = 1'b0;
    repeat (2) begin
      @(posedge clk); #1;
      check({rail_p, rail_n, rail_any} == 3'b000, "R1 reset outputs",
            {rail_p, rail_n, rail_any}, 3'b000);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // builds expectations (model or hand), resets, streams n bits and checks
  task automatic play(input int n, input bit hand, input string htag);
    int zr = 0;
    bit odd = 0;
    bit lastp = 0;
    int sym [112];      // 0 zero, 1 mark, 2 viol, 3 bal
    bit withb [112];
    for (int i = n; i < n + 3; i++) begin
      d_bit[i] = 1'b0;
      d_mode[i] = d_mode[n-1];
    end
    for (int i = 0; i < n + 3; i++) begin
      withb[i] = 0;
      if (d_bit[i]) begin
        sym[i] = 1; zr = 0; odd = !odd;
      end else if (zr == 3 && d_mode[i]) begin
        sym[i] = 2;
        if (!odd) begin sym[i-3] = 3; withb[i] = 1; end
        odd = 0; zr = 0;
      end else begin
        sym[i] = 0;
        if (zr < 3) zr++;
      end
    end
    for (int i = 0; i < n + 3; i++) begin
      if (sym[i] == 1 || sym[i] == 3) begin
        lastp = !lastp;
        d_exp[i] = lastp ? 2'b10 : 2'b01;
        d_tag[i] = (sym[i] == 1) ? "R2 R3 mark" : "R2 R5 balance";
      end else if (sym[i] == 2) begin
        d_exp[i] = lastp ? 2'b10 : 2'b01;
        d_tag[i] = withb[i] ? "R2 R5 R6 viol after B" : "R2 R4 R6 viol";
      end else begin
        d_exp[i] = 2'b00;
        d_tag[i] = d_mode[i] ? "R2 zero" : "R7 AMI zero";
      end
      if (hand && i < n) begin
        d_exp[i] = h_exp[i];
        d_tag[i] = htag;
      end
    end
    do_reset();
    for (int t = 0; t < n + 3; t++) begin
      if (t > 0) @(negedge clk);
      nrz_in = d_bit[t];
      hdb3_en = d_mode[t];
      #1;
      check({rail_p, rail_n, rail_any} == 3'b000, "R9 low half-period",
            {rail_p, rail_n, rail_any}, 3'b000);
      @(posedge clk); #1;
      if (t >= 3) begin
        check({rail_p, rail_n} == d_exp[t-3], d_tag[t-3],
              {1'b0, rail_p, rail_n}, {1'b0, d_exp[t-3]});
        check(!(rail_p && rail_n) && rail_any == (rail_p || rail_n),
              "R8 exclusive and OR", {rail_p, rail_n, rail_any},
              {d_exp[t-3], |d_exp[t-3]});
      end else begin
        check({rail_p, rail_n} == 2'b00, "R1 R2 empty pipeline",
              {1'b0, rail_p, rail_n}, 3'b000);
      end
    end
  endtask

  initial begin
    // main table, one continuous stream
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < 16; k++) begin
        d_bit[r*16+k]  = PAT_BITS[r][15-k];
        d_mode[r*16+k] = PAT_MODE[r];
      end
    play(ROWS*16, 0, "");

    // R1 R5: after reset, 0000 gives B00V with both pulses positive
    d_bit[0]=0; d_bit[1]=0; d_bit[2]=0; d_bit[3]=0; d_bit[4]=1;
    for (int i = 0; i < 5; i++) d_mode[i] = 1'b1;
    h_exp[0]=2'b10; h_exp[1]=2'b00; h_exp[2]=2'b00; h_exp[3]=2'b10; h_exp[4]=2'b01;
    play(5, 1, "R1 R5 B00V after reset");

    // R4: 1 0000 1 gives + 0 0 0 + -
    d_bit[0]=1; d_bit[1]=0; d_bit[2]=0; d_bit[3]=0; d_bit[4]=0; d_bit[5]=1;
    for (int i = 0; i < 6; i++) d_mode[i] = 1'b1;
    h_exp[0]=2'b10; h_exp[1]=2'b00; h_exp[2]=2'b00; h_exp[3]=2'b00;
    h_exp[4]=2'b10; h_exp[5]=2'b01;
    play(6, 1, "R4 000V");

    // R10: zeros in AMI, fourth zero in HDB3 -> substituted
    d_bit[0]=1; d_bit[1]=0; d_bit[2]=0; d_bit[3]=0; d_bit[4]=0; d_bit[5]=1;
    d_mode[0]=0; d_mode[1]=0; d_mode[2]=0; d_mode[3]=0; d_mode[4]=1; d_mode[5]=1;
    play(6, 1, "R10 mode taken at fourth zero");

    // R10 R7: zeros in HDB3, fourth zero in AMI -> no substitution
    d_bit[0]=0; d_bit[1]=0; d_bit[2]=0; d_bit[3]=0; d_bit[4]=1;
    d_mode[0]=1; d_mode[1]=1; d_mode[2]=1; d_mode[3]=0; d_mode[4]=0;
    h_exp[0]=2'b00; h_exp[1]=2'b00; h_exp[2]=2'b00; h_exp[3]=2'b00; h_exp[4]=2'b10;
    play(5, 1, "R10 R7 run ended in AMI");

    // R1: polarity restarts after a mid-stream reset
    d_bit[0]=1; d_bit[1]=1; d_bit[2]=1;
    for (int i = 0; i < 3; i++) d_mode[i] = 1'b1;
    play(3, 0, "");
    d_bit[0]=1; d_mode[0]=1'b1;
    h_exp[0]=2'b10;
    play(1, 1, "R1 first pulse positive after reset");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule